// File: doc/BRIEF.md
# Data-Processing Execute Unit

This block executes one 32-bit data-processing instruction word at a time. It decodes the operation, reads the source operands from its own register file of 16 words of 32 bits, combines operand 1 with an operand-2 value and writes the result back on the next rising clock edge. The operand-2 value comes in already prepared by an external shifter or rotator, so the unit uses it unchanged in both the register and the immediate forms.

The operations are bitwise AND, exclusive OR, OR, subtract, reverse subtract, add and move. A multiply encoding that lives inside the register-form AND space is also recognised. It has its own placement of the destination and source register fields and ignores operand 2. Any word outside these encodings raises an illegal flag and writes nothing. No condition codes are evaluated or produced, and all arithmetic wraps modulo 2^32.

Top module: `dp_exec_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all 16 registers are cleared to zero.
- R2: Opcode field bits 24..21 = 0000 gives op1 AND op2, 0001 gives op1 XOR op2, and 1100 gives op1 OR op2. Here op1 is the register named in bits 19..16 and op2 is `op2_in`.
- R3: Opcode 0010 gives op1 - op2, 0011 gives op2 - op1 and 0100 gives op1 + op2, all modulo 2^32.
- R4: Opcode 1101 (move) gives a result equal to `op2_in`, whatever the register selected by bits 19..16 holds.
- R5: Type field bits 27..25 = 000 (register form) and 001 (immediate form) are both accepted, and both take operand 2 from `op2_in`.
- R6: Outside multiply, `rd_num` equals bits 15..12.
- R7: A word with condition field 1110, type 000, opcode 0000 and bits 7..4 = 1001 is a multiply. `rd_num` is bits 19..16, and the result is the low 32 bits of reg[bits 3..0] * reg[bits 11..8]. `op2_in` has no effect on it.
- R8: Bits 31..28 other than 1110, a type other than 000 or 001, or an opcode outside the listed set raise `illegal` with `wr_en` low, and the register file is left unchanged.
- R9: `wr_en` is high exactly when `instr_vld` is high and the word is legal. The register named by `rd_num` takes `result` at that rising edge. Reads are combinational, so a write is visible from the next cycle on.
- R10: The words 0xe0821283 (with op2 = r3 << 5), 0xe3821f21 (with op2 = 0x84) and 0xe0010392 decode to r1 = r2 + op2, r1 = r2 | op2 and r1 = r2 * r3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| op2_in | input | 32 | Operand 2 as prepared by the external shifter |
| rd_num | output | 4 | Destination register number |
| wr_en | output | 1 | Register write enable |
| result | output | 32 | Computed result |
| illegal | output | 1 | Word is not a supported data-processing encoding |

## Verification
The assertions assume that `instr` and `op2_in` are stable between clock edges. They also assume that `op2_in` is whatever the outside shifter produced, so no relation between `op2_in` and the low instruction bits is checked. The bench changes inputs only at the falling edge and computes op2 itself, for example the rotated immediate and the shifted register of the reference words. This keeps the stimulus inside those assumptions. Illegal words are sent with `instr_vld` high, so that the check of no write applies to cycles in which a write would otherwise happen.

// File: rtl/dp_pkg.sv
// Shared types for the data-processing execute unit.
// Assumes the fixed 32-bit word layout with 4-bit register fields.
package dp_pkg;
    localparam int REG_IDX_W = 4;

    typedef enum logic [3:0] {
        K_AND, K_EOR, K_SUB, K_RSB, K_ADD, K_ORR, K_MOV, K_MUL, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e                 kind;
        logic [REG_IDX_W-1:0]  rd;
        logic [REG_IDX_W-1:0]  rn;
        logic [REG_IDX_W-1:0]  rm;
        logic [REG_IDX_W-1:0]  rs;
    } dec_t;
endpackage

// File: rtl/dp_decode.sv
// Instruction decoder: classifies the word and extracts register fields.
// Assumes a 32-bit word; multiply relocates the destination field.
module dp_decode
    import dp_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    localparam logic [3:0] COND_AL = 4'b1110;
    localparam logic [3:0] MUL_TAG = 4'b1001;

    logic [3:0] cond_f;
    logic [2:0] type_f;
    logic [3:0] opc_f;
    logic       is_mul;

    assign cond_f = instr[31:28];
    assign type_f = instr[27:25];
    assign opc_f  = instr[24:21];
    assign is_mul = (cond_f == COND_AL) && (type_f == 3'b000) &&
                    (opc_f == 4'b0000) && (instr[7:4] == MUL_TAG);

    // Pick operation kind and register numbers from the word.
    always_comb begin
        dec.rm = instr[3:0];
        dec.rs = instr[11:8];
        dec.rn = instr[19:16];
        dec.rd = instr[15:12];
        dec.kind = K_BAD;
        if (is_mul) begin
            dec.kind = K_MUL;
            dec.rd   = instr[19:16];
        end else if ((cond_f == COND_AL) && (type_f[2:1] == 2'b00)) begin
            unique case (opc_f)
                4'b0000: dec.kind = K_AND;
                4'b0001: dec.kind = K_EOR;
                4'b0010: dec.kind = K_SUB;
                4'b0011: dec.kind = K_RSB;
                4'b0100: dec.kind = K_ADD;
                4'b1100: dec.kind = K_ORR;
                4'b1101: dec.kind = K_MOV;
                default: dec.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/dp_alu.sv
// Result datapath: logic, add/subtract, move and low-half multiply.
// Assumes operands already selected; arithmetic wraps at W bits.
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 32
) (
    input  kind_e        kind,
    input  logic [W-1:0] op1,
    input  logic [W-1:0] op2,
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    output logic [W-1:0] res
);
    logic [W-1:0] prod;

    assign prod = mul_a * mul_b;

    // Select the result for the decoded operation.
    always_comb begin
        unique case (kind)
            K_AND:   res = op1 & op2;
            K_EOR:   res = op1 ^ op2;
            K_SUB:   res = op1 - op2;
            K_RSB:   res = op2 - op1;
            K_ADD:   res = op1 + op2;
            K_ORR:   res = op1 | op2;
            K_MOV:   res = op2;
            K_MUL:   res = prod;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dp_regfile.sv
// Register file with three combinational read ports and one write port.
// Assumes synchronous active-low reset clearing every entry.
module dp_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] mem [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_ent
            // Clear on reset, else capture write data when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    mem[g] <= wdata;
            end
        end
    endgenerate

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];
endmodule

// File: rtl/dp_exec_unit.sv
// Top: decodes a data-processing word, reads sources, computes and writes back.
// Assumes op2_in is already shifted/rotated by an external unit.
module dp_exec_unit
    import dp_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREGS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_vld,
    input  logic [31:0]   instr,
    input  logic [W-1:0]  op2_in,
    output logic [3:0]    rd_num,
    output logic          wr_en,
    output logic [W-1:0]  result,
    output logic          illegal
);
    dec_t         dec;
    logic [W-1:0] rn_val;
    logic [W-1:0] rm_val;
    logic [W-1:0] rs_val;
    logic [3:0]   rn_idx;

    dp_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rn_idx = dec.rn;

    dp_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (rd_num),
        .wdata (result),
        .ra0   (rn_idx),
        .ra1   (dec.rm),
        .ra2   (dec.rs),
        .rd0   (rn_val),
        .rd1   (rm_val),
        .rd2   (rs_val)
    );

    dp_alu #(.W(W)) u_alu (
        .kind  (dec.kind),
        .op1   (rn_val),
        .op2   (op2_in),
        .mul_a (rm_val),
        .mul_b (rs_val),
        .res   (result)
    );

    assign rd_num  = dec.rd;
    assign illegal = (dec.kind == K_BAD);
    assign wr_en   = instr_vld && !illegal;
endmodule

// File: rtl/dp_exec_chk.sv
// Checker for dp_exec_unit: relates ports and register reads over time.
// Assumes inputs change only between clock edges.
module dp_exec_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [31:0]  instr,
    input logic [W-1:0] op2_in,
    input logic [3:0]   rd_num,
    input logic         wr_en,
    input logic [W-1:0] result,
    input logic         illegal,
    input logic [3:0]   rn_idx,
    input logic [W-1:0] rn_val
);
    // R8
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);

    // R4
    move_passes_op2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:28] == 4'b1110 && instr[27:26] == 2'b00 && instr[24:21] == 4'b1101)
        |-> (result == op2_in && !illegal));

    // R7
    mul_dest_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:21] == 11'b1110_000_0000 && instr[7:4] == 4'b1001)
        |-> (rd_num == instr[19:16] && !illegal));

    // R9
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rn_idx != $past(rd_num)) || (rn_val == $past(result)));

    // R3
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:28] == 4'b1110 && instr[27:26] == 2'b00 && instr[24:21] == 4'b0100)
        |-> result == rn_val + op2_in);
endmodule

bind dp_exec_unit dp_exec_chk #(.W(W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr   (instr),
    .op2_in  (op2_in),
    .rd_num  (rd_num),
    .wr_en   (wr_en),
    .result  (result),
    .illegal (illegal),
    .rn_idx  (rn_idx),
    .rn_val  (rn_val)
);

// File: tb/test_dp_exec_unit.sv
module test_dp_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] op2_in = 32'h0;
    logic [3:0]  rd_num;
    logic        wr_en;
    logic [31:0] result;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] model [16];

    always #4 clk = ~clk;

    dp_exec_unit i_dp_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
        .op2_in(op2_in), .rd_num(rd_num), .wr_en(wr_en), .result(result),
        .illegal(illegal)
    );

    function automatic logic [31:0] enc(input logic [3:0] cnd, input logic [2:0] typ,
                                        input logic [3:0] opc, input logic [3:0] rn,
                                        input logic [3:0] rd, input logic [11:0] low);
        return {cnd, typ, opc, 1'b0, rn, rd, low};
    endfunction

    task automatic report(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one word, compare against the behavioural model, then advance.
    task automatic step(input logic [31:0] ins, input logic [31:0] op2,
                        input logic vld, input string tag);
        logic [3:0] cnd, opc, e_rd;
        logic [2:0] typ;
        logic [31:0] a, e_res;
        logic e_ill, e_we;
        longint unsigned p;
        @(negedge clk);
        instr = ins; op2_in = op2; instr_vld = vld;
        cnd = ins[31:28]; typ = ins[27:25]; opc = ins[24:21];
        a = model[ins[19:16]];
        e_ill = 1'b0; e_rd = ins[15:12]; e_res = 32'h0;
        if (cnd == 4'he && typ == 3'd0 && opc == 4'd0 && ins[7:4] == 4'h9) begin
            e_rd = ins[19:16];
            p = longint'(model[ins[3:0]]) * longint'(model[ins[11:8]]);
            e_res = p[31:0];
        end else if (cnd != 4'he || typ > 3'd1) begin
            e_ill = 1'b1;
        end else begin
            case (opc)
                4'd0:  e_res = a & op2;
                4'd1:  e_res = a ^ op2;
                4'd2:  e_res = a - op2;
                4'd3:  e_res = op2 - a;
                4'd4:  e_res = a + op2;
                4'd12: e_res = a | op2;
                4'd13: e_res = op2;
                default: e_ill = 1'b1;
            endcase
        end
        e_we = vld && !e_ill;
        #2;
        report(tag, "illegal", {31'b0, illegal}, {31'b0, e_ill});
        report(tag, "wr_en", {31'b0, wr_en}, {31'b0, e_we});
        if (!e_ill) begin
            report(tag, "rd_num", {28'b0, rd_num}, {28'b0, e_rd});
            report(tag, "result", result, e_res);
        end
        @(posedge clk);
        if (e_we) model[e_rd] = e_res;
    endtask

    // Observe register k through an add with zero that writes it back.
    task automatic peek(input int k, input string tag);
        step(enc(4'he, 3'd1, 4'd4, 4'(k), 4'(k), 12'h0), 32'h0, 1'b1, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Fill registers with move-immediate, then reset and read zeros (R1)
        for (int i = 0; i < 16; i++)
            step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'(i), 12'h0), 32'hA5A50000 + i, 1'b1, "R4");
        @(negedge clk); rst_n = 1'b0; instr_vld = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = 32'h0;
        for (int i = 0; i < 16; i++) peek(i, "R1");
        // Load operands
        step(enc(4'he, 3'd1, 4'd13, 4'd7, 4'd2, 12'h0), 32'hF0F0_1234, 1'b1, "R4");
        step(enc(4'he, 3'd0, 4'd13, 4'd2, 4'd3, 12'h003), 32'h0000_0007, 1'b1, "R5");
        step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'd4, 12'h0), 32'hFFFF_FFFF, 1'b1, "R4");
        step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'd5, 12'h0), 32'h8000_0001, 1'b1, "R4");
        // Bitwise operations, both forms (R2)
        step(enc(4'he, 3'd1, 4'd0, 4'd2, 4'd6, 12'h0), 32'h0FF0_FF00, 1'b1, "R2");
        step(enc(4'he, 3'd0, 4'd1, 4'd2, 4'd7, 12'h004), 32'h3333_3333, 1'b1, "R2");
        step(enc(4'he, 3'd0, 4'd12, 4'd3, 4'd8, 12'h002), 32'h1000_0000, 1'b1, "R2");
        // Arithmetic and wrap-around (R3)
        step(enc(4'he, 3'd1, 4'd2, 4'd3, 4'd9, 12'h0), 32'd9, 1'b1, "R3");
        step(enc(4'he, 3'd0, 4'd3, 4'd3, 4'd10, 12'h0), 32'd2, 1'b1, "R3");
        step(enc(4'he, 3'd1, 4'd4, 4'd4, 4'd11, 12'h0), 32'd5, 1'b1, "R3");
        step(enc(4'he, 3'd0, 4'd4, 4'd5, 4'd11, 12'h0), 32'h8000_0000, 1'b1, "R3");
        // Move ignores Rn (R4) and register form uses op2_in (R5), dest field (R6)
        step(enc(4'he, 3'd0, 4'd13, 4'd4, 4'd12, 12'h0), 32'h0000_00AB, 1'b1, "R6");
        // Multiply with large operands and op2 junk (R7)
        step({4'he, 3'd0, 4'd0, 1'b0, 4'd13, 4'd0, 4'd5, 4'h9, 4'd4}, 32'hDEAD_BEEF, 1'b1, "R7");
        step({4'he, 3'd0, 4'd0, 1'b0, 4'd14, 4'd9, 4'd2, 4'h9, 4'd3}, 32'h1234_5678, 1'b1, "R7");
        peek(13, "R7");
        // Illegal words leave registers alone (R8)
        step(enc(4'he, 3'd0, 4'd5, 4'd2, 4'd2, 12'h0), 32'h1, 1'b1, "R8");
        step(enc(4'he, 3'd2, 4'd4, 4'd2, 4'd2, 12'h0), 32'h1, 1'b1, "R8");
        step(enc(4'h0, 3'd1, 4'd13, 4'd2, 4'd2, 12'h0), 32'h1, 1'b1, "R8");
        step(enc(4'he, 3'd1, 4'd15, 4'd2, 4'd2, 12'h0), 32'h1, 1'b1, "R8");
        peek(2, "R8");
        // No write without valid (R9)
        step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'd6, 12'h0), 32'h5555_AAAA, 1'b0, "R9");
        peek(6, "R9");
        // Reference words (R10)
        step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'd2, 12'h0), 32'h0000_0100, 1'b1, "R10");
        step(enc(4'he, 3'd1, 4'd13, 4'd0, 4'd3, 12'h0), 32'h0000_0011, 1'b1, "R10");
        step(32'he0821283, model[3] << 5, 1'b1, "R10");
        step(32'he3821f21, 32'h0000_0084, 1'b1, "R10");
        step(32'he0010392, 32'hFFFF_0000, 1'b1, "R10");
        peek(1, "R10");
        @(negedge clk); instr_vld = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule